// File: doc/BRIEF.md
# Two-Rate Three-Color Packet Policer

This block meters a stream of packet descriptors against one policing profile that has two token buckets: a committed bucket and a peak bucket. Each packet is given a color (green, yellow or red) and a pass/drop verdict. The result appears one cycle after the descriptor. Rates and bucket depths are written as floating values of the form (1 + M/256)·2^E tokens through a small register write port. A token is one byte in length mode and one packet in packet mode.

A periodic timeunit strobe drives the refill. A programmable divider stretches the refill period to 2^D strobes. The cost of each packet is computed with 1/256-token precision. It is the packet length minus a configurable header offset, or zero in packet mode, plus a signed adjustment term. The cost never falls below 1/256 token. Bucket levels are held in fixed point with eight fractional bits, so every cost and increment is exact.

Top module: `tcm_policer`

## Requirements
- R1: After reset, both buckets have zero size, the cost is the packet length in tokens, the divider is 0, and the actions are green pass, yellow pass, red drop. Every packet is therefore red and dropped. Register map, where E is bits [12:8] and M is bits [7:0]:
  - address 0: committed rate
  - address 1: committed depth
  - address 2: peak rate
  - address 3: peak depth
  - address 4: cost. Adjust mantissa [8:0], adjust exponent [13:9], packet mode [14], header offset [31:16].
  - address 5: control. Divider D [3:0], green action [5:4], yellow action [7:6], red action [9:8].
- R2: `res_valid_o` pulses exactly one cycle after `pkt_valid_i`. Color and drop are valid in that same cycle. Color codes are green 0, yellow 1, red 2.
- R3: Each refill adds (256+M)·2^E /256 tokens to each bucket. A refill happens on every 2^D-th strobe of `tick_i`, counted from the last configuration write.
- R4: A bucket level never exceeds its depth (256+M)·2^E /256 tokens. Refill saturates at that depth.
- R5: A rate or depth exponent of 24 or more gives zero, so a bucket with such a depth never pays for a packet.
- R6: The packet cost in tokens is (length − header offset) + (adjust mantissa/256 − 1)·2^(adjust exponent), with 1/256 resolution.
- R7: A cost at or below zero is raised to 1/256 token.
- R8: With packet mode 1, adjust mantissa 384 and adjust exponent 1, each packet costs exactly one token whatever its length.
- R9: A packet is green if the committed bucket covers its cost, and only that bucket is debited. Otherwise it is yellow if the peak bucket covers the cost, and only the peak bucket is debited. Otherwise it is red, and nothing is debited.
- R10: The 2-bit action field of the resulting color sets `res_drop_o`: 0 means pass and any other value means drop.
- R11: Any write to a defined address fills both buckets to their new depth before the next packet. It also restarts the refill divider.
- R12: When a refill and a packet fall in the same cycle, the refill is applied before the packet is metered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration register address |
| cfg_wdata_i | input | 32 | Configuration write data |
| tick_i | input | 1 | Timeunit strobe, one cycle per timeunit |
| pkt_valid_i | input | 1 | Packet descriptor valid |
| pkt_len_i | input | 16 | Packet length in bytes |
| res_valid_o | output | 1 | Result valid, one cycle after the descriptor |
| res_color_o | output | 2 | Result color: 0 green, 1 yellow, 2 red |
| res_drop_o | output | 1 | Drop verdict from the action of the resulting color |

## Verification
A wrong bucket level inside the block is not seen directly at the ports. It shows up as a wrong color on the first packet whose cost crosses the true level. For that reason the scenarios drain a bucket to a known edge and then probe it one token on either side of that edge. A miscounted divider or a dropped refill shows on the first packet sent after the expected refill strobe. A wrong cost term changes the color within two packets of a carefully sized depth.

// File: rtl/tcm_pol_pkg.sv
package tcm_pol_pkg;
  localparam int unsigned EXP_W      = 5;
  localparam int unsigned MANT_W     = 8;
  localparam int unsigned ADJ_MANT_W = 9;
  localparam int unsigned RDIV_W     = 4;
  localparam int unsigned FRAC_W     = 8;
  localparam int unsigned LEN_W      = 16;
  localparam int unsigned LVL_W      = 40;
  localparam int unsigned COST_W     = 48;
  localparam int unsigned ZERO_EXP   = 24;
  localparam int unsigned ADDR_W     = 3;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned NB         = 2;

  typedef enum logic [1:0] {
    CLR_GREEN  = 2'd0,
    CLR_YELLOW = 2'd1,
    CLR_RED    = 2'd2
  } color_e;

  typedef struct packed {
    logic [EXP_W-1:0]  e;
    logic [MANT_W-1:0] m;
  } fp_t;

  typedef struct packed {
    fp_t                   c_rate;
    fp_t                   c_depth;
    fp_t                   p_rate;
    fp_t                   p_depth;
    logic [ADJ_MANT_W-1:0] adj_m;
    logic [EXP_W-1:0]      adj_e;
    logic                  lmode;
    logic [LEN_W-1:0]      lxptr;
    logic [RDIV_W-1:0]     rdiv;
    logic [1:0]            act_g;
    logic [1:0]            act_y;
    logic [1:0]            act_r;
  } cfg_t;

  // (256+m)<<e in 1/256-token units; large exponent means zero size
  function automatic logic [LVL_W-1:0] fp_units(fp_t v);
    if (v.e >= EXP_W'(ZERO_EXP)) return '0;
    return LVL_W'({1'b1, v.m}) << v.e;
  endfunction
endpackage

// File: rtl/tcm_pol_cfg.sv
module tcm_pol_cfg
  import tcm_pol_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output cfg_t              cfg_o,
  output logic              wr_o
);
  localparam logic [ADDR_W-1:0] A_CRATE  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CDEPTH = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_PRATE  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_PDEPTH = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_COST   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(5);
  localparam int unsigned FP_W      = EXP_W + MANT_W;
  localparam int unsigned ADJ_E_LSB = ADJ_MANT_W;
  localparam int unsigned LMODE_BIT = ADJ_MANT_W + EXP_W;
  localparam int unsigned LXPTR_LSB = DATA_W - LEN_W;
  localparam int unsigned ACT_LSB   = RDIV_W;

  localparam fp_t FP_OFF = '{e: EXP_W'(ZERO_EXP), m: '0};

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  assign wr_o = we_i && (addr_i <= A_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o.c_rate  <= FP_OFF;
      cfg_o.c_depth <= FP_OFF;
      cfg_o.p_rate  <= FP_OFF;
      cfg_o.p_depth <= FP_OFF;
      cfg_o.adj_m   <= ADJ_MANT_W'(1 << FRAC_W);
      cfg_o.adj_e   <= '0;
      cfg_o.lmode   <= 1'b0;
      cfg_o.lxptr   <= '0;
      cfg_o.rdiv    <= '0;
      cfg_o.act_g   <= 2'd0;
      cfg_o.act_y   <= 2'd0;
      cfg_o.act_r   <= 2'd1;
    end else if (we_i) begin
      case (addr_i)
        A_CRATE:  cfg_o.c_rate  <= fp_t'(wdata_i[FP_W-1:0]);
        A_CDEPTH: cfg_o.c_depth <= fp_t'(wdata_i[FP_W-1:0]);
        A_PRATE:  cfg_o.p_rate  <= fp_t'(wdata_i[FP_W-1:0]);
        A_PDEPTH: cfg_o.p_depth <= fp_t'(wdata_i[FP_W-1:0]);
        A_COST: begin
          cfg_o.adj_m <= wdata_i[ADJ_MANT_W-1:0];
          cfg_o.adj_e <= wdata_i[ADJ_E_LSB +: EXP_W];
          cfg_o.lmode <= wdata_i[LMODE_BIT];
          cfg_o.lxptr <= wdata_i[LXPTR_LSB +: LEN_W];
        end
        A_CTRL: begin
          cfg_o.rdiv  <= wdata_i[RDIV_W-1:0];
          cfg_o.act_g <= wdata_i[ACT_LSB +: 2];
          cfg_o.act_y <= wdata_i[ACT_LSB+2 +: 2];
          cfg_o.act_r <= wdata_i[ACT_LSB+4 +: 2];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tcm_pol_timer.sv
module tcm_pol_timer
  import tcm_pol_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              clr_i,
  input  logic [RDIV_W-1:0] rdiv_i,
  output logic              refill_o
);
  localparam int unsigned CNT_W = (1 << RDIV_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  assign lim      = CNT_W'((32'd1 << rdiv_i) - 32'd1);
  assign refill_o = tick_i && !clr_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (tick_i)  cnt_q <= refill_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/tcm_pol_cost.sv
module tcm_pol_cost
  import tcm_pol_pkg::*;
(
  input  logic [LEN_W-1:0]      len_i,
  input  logic [LEN_W-1:0]      lxptr_i,
  input  logic                  lmode_i,
  input  logic [ADJ_MANT_W-1:0] adj_m_i,
  input  logic [EXP_W-1:0]      adj_e_i,
  output logic [COST_W-1:0]     cost_o
);
  logic signed [COST_W-1:0] base, adj, sum;

  always_comb begin
    base = lmode_i ? '0
                   : ($signed(COST_W'(len_i)) - $signed(COST_W'(lxptr_i))) <<< FRAC_W;
    adj  = ($signed(COST_W'(adj_m_i)) - $signed(COST_W'(1 << FRAC_W))) <<< adj_e_i;
    sum  = base + adj;
    // floor of 1/256 token
    if (sum <= $signed(COST_W'(0))) cost_o = COST_W'(1);
    else                            cost_o = COST_W'(sum);
  end
endmodule

// File: rtl/tcm_pol_bucket.sv
module tcm_pol_bucket
  import tcm_pol_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] rate_i,
  input  logic [LVL_W-1:0] depth_i,
  input  logic             refill_i,
  input  logic             fill_i,
  input  logic             debit_i,
  input  logic [LVL_W-1:0] cost_i,
  output logic [LVL_W-1:0] avail_o
);
  logic [LVL_W-1:0] lvl_q;
  logic [LVL_W:0]   sum;

  always_comb begin
    sum = {1'b0, lvl_q} + (refill_i ? {1'b0, rate_i} : '0);
    if (fill_i || (sum > {1'b0, depth_i})) avail_o = depth_i;
    else                                   avail_o = sum[LVL_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lvl_q <= '0;
    else if (debit_i) lvl_q <= avail_o - cost_i;
    else              lvl_q <= avail_o;
  end
endmodule

// File: rtl/tcm_policer.sv
module tcm_policer
  import tcm_pol_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  input  logic              tick_i,
  input  logic              pkt_valid_i,
  input  logic [LEN_W-1:0]  pkt_len_i,
  output logic              res_valid_o,
  output logic [1:0]        res_color_o,
  output logic              res_drop_o
);
  cfg_t              cfg;
  logic              cfg_wr, fill_q, refill;
  logic [COST_W-1:0] cost;
  logic [LVL_W-1:0]  rate_u  [NB];
  logic [LVL_W-1:0]  depth_u [NB];
  logic [LVL_W-1:0]  avail   [NB];
  logic              ok      [NB];
  logic              debit   [NB];
  color_e            color;
  logic [1:0]        act;

  tcm_pol_cfg u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .cfg_o(cfg), .wr_o(cfg_wr)
  );

  tcm_pol_timer u_tmr (
    .clk_i, .rst_ni,
    .tick_i, .clr_i(cfg_wr), .rdiv_i(cfg.rdiv), .refill_o(refill)
  );

  tcm_pol_cost u_cost (
    .len_i(pkt_len_i), .lxptr_i(cfg.lxptr), .lmode_i(cfg.lmode),
    .adj_m_i(cfg.adj_m), .adj_e_i(cfg.adj_e), .cost_o(cost)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fill_q <= 1'b0;
    else         fill_q <= cfg_wr;
  end

  assign rate_u[0]  = fp_units(cfg.c_rate);
  assign depth_u[0] = fp_units(cfg.c_depth);
  assign rate_u[1]  = fp_units(cfg.p_rate);
  assign depth_u[1] = fp_units(cfg.p_depth);

  // committed pays first, peak only when committed cannot
  assign debit[0] = pkt_valid_i && ok[0];
  assign debit[1] = pkt_valid_i && !ok[0] && ok[1];

  for (genvar b = 0; b < NB; b++) begin : g_bkt
    assign ok[b] = {{(COST_W-LVL_W){1'b0}}, avail[b]} >= cost;
    tcm_pol_bucket u_bkt (
      .clk_i, .rst_ni,
      .rate_i(rate_u[b]), .depth_i(depth_u[b]),
      .refill_i(refill), .fill_i(fill_q),
      .debit_i(debit[b]), .cost_i(cost[LVL_W-1:0]),
      .avail_o(avail[b])
    );
  end

  always_comb begin
    if (ok[0])      begin color = CLR_GREEN;  act = cfg.act_g; end
    else if (ok[1]) begin color = CLR_YELLOW; act = cfg.act_y; end
    else            begin color = CLR_RED;    act = cfg.act_r; end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_color_o <= CLR_GREEN;
      res_drop_o  <= 1'b0;
    end else begin
      res_valid_o <= pkt_valid_i;
      if (pkt_valid_i) begin
        res_color_o <= color;
        res_drop_o  <= (act != 2'd0);
      end
    end
  end
endmodule

// File: rtl/tcm_pol_chk.sv
module tcm_pol_chk
  import tcm_pol_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pkt_valid_i,
  input logic             res_valid_o,
  input logic [1:0]       res_color_o,
  input logic             refill_i,
  input logic             fill_i,
  input logic [LVL_W-1:0] c_avail_i,
  input logic [LVL_W-1:0] p_avail_i
);
  AST_RES_FOLLOWS_PKT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_i |=> res_valid_o); // R2
  AST_NO_RES_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pkt_valid_i |=> !res_valid_o); // R2
  AST_COLOR_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> res_color_o != 2'd3); // R9
  AST_RED_NO_DEBIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_color_o == CLR_RED && !refill_i && !fill_i)
      |-> (c_avail_i == $past(c_avail_i) && p_avail_i == $past(p_avail_i))); // R9
  AST_YELLOW_SPARES_C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_color_o == CLR_YELLOW && !refill_i && !fill_i)
      |-> c_avail_i == $past(c_avail_i)); // R9
endmodule

bind tcm_policer tcm_pol_chk u_chk (
  .clk_i, .rst_ni, .pkt_valid_i, .res_valid_o, .res_color_o,
  .refill_i(refill), .fill_i(fill_q),
  .c_avail_i(avail[0]), .p_avail_i(avail[1])
);

// File: tb/tcm_policer_tb_top.sv
`timescale 1ns/1ps
module tcm_policer_tb_top;
  localparam real CLK_NS = 4.0;
  localparam logic [1:0] G = 2'd0, Y = 2'd1, R = 2'd2;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_addr_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic        tick_i = 1'b0;
  logic        pkt_valid_i = 1'b0;
  logic [15:0] pkt_len_i = '0;
  logic        res_valid_o;
  logic [1:0]  res_color_o;
  logic        res_drop_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  tcm_policer dut_i (
    .clk_i(clk), .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i,
    .tick_i, .pkt_valid_i, .pkt_len_i,
    .res_valid_o, .res_color_o, .res_drop_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
    end
  endtask

  // result packed as {valid, color, drop}
  task automatic send(input string tag, input int len, input logic [1:0] c,
                      input logic d, input bit with_tick = 1'b0);
    @(negedge clk);
    pkt_valid_i = 1'b1; pkt_len_i = 16'(len); tick_i = with_tick;
    @(negedge clk);
    pkt_valid_i = 1'b0; tick_i = 1'b0;
    chk(tag, {28'd0, res_valid_o, res_color_o, res_drop_o}, {28'd0, 1'b1, c, d});
  endtask

  task automatic t_reset;
    chk("R1 idle after reset", {31'd0, res_valid_o}, 32'd0);
    send("R1 reset red/drop", 64, R, 1'b1);
    @(negedge clk);
    chk("R2 valid single pulse", {31'd0, res_valid_o}, 32'd0);
  endtask

  task automatic t_bytes;
    wr(3'd0, 32'h0600);   // committed rate 64 tokens
    wr(3'd1, 32'h0A00);   // committed depth 1024 tokens
    wr(3'd5, 32'h0100);   // div 0, red drop
    send("R9 green 600", 600, G, 1'b0);
    send("R9 green 400", 400, G, 1'b0);
    send("R5 zero peak gives red", 100, R, 1'b1);
    tick(1);
    send("R3 refill 64 -> 88 pays", 88, G, 1'b0);
    send("R9 empty red", 1, R, 1'b1);
    send("R7 zero cost floors to 1/256", 0, R, 1'b1);
    tick(1);
    send("R7 floor cost green", 0, G, 1'b0);
    send("R6 fractional short by 1/256", 64, R, 1'b1);
    send("R6 63 fits", 63, G, 1'b0);
  endtask

  task automatic t_sat_and_order;
    tick(20);
    send("R4 over depth red", 1025, R, 1'b1);
    send("R4 saturated at depth", 1024, G, 1'b0);
    send("R12 refill before packet", 64, G, 1'b0, 1'b1);
  endtask

  task automatic t_rdiv;
    wr(3'd5, 32'h0102);   // div 2
    send("R11 write fills committed", 1024, G, 1'b0);
    tick(3);
    send("R3 no refill before 4th tick", 1, R, 1'b1);
    tick(1);
    send("R3 refill on 4th tick", 64, G, 1'b0);
    send("R3 only one refill", 1, R, 1'b1);
  endtask

  task automatic t_yellow;
    wr(3'd3, 32'h0900);   // peak depth 512
    send("R9 green first", 1024, G, 1'b0);
    send("R9 yellow from peak", 300, Y, 1'b0);
    send("R9 peak short red", 300, R, 1'b1);
    send("R9 red kept peak level", 212, Y, 1'b0);
    send("R9 both empty", 1, R, 1'b1);
    wr(3'd5, 32'h0142);   // yellow action drop
    send("R10 green pass", 1024, G, 1'b0);
    send("R10 yellow drop", 512, Y, 1'b1);
    send("R10 red drop", 1, R, 1'b1);
  endtask

  task automatic t_pps;
    wr(3'd3, 32'h1800);
    wr(3'd1, 32'h0200);   // 4 tokens
    wr(3'd4, 32'h4380);   // packet mode, one token each
    for (int i = 0; i < 4; i++) send("R8 one token per packet", 1500, G, 1'b0);
    send("R8 fifth packet red", 9, R, 1'b1);
  endtask

  task automatic t_offset;
    wr(3'd4, 32'h0014_0100);  // offset 20, no adjust
    wr(3'd1, 32'h0690);       // depth 100 tokens
    send("R6 offset cost 80", 100, G, 1'b0);
    send("R6 offset cost 20", 40, G, 1'b0);
    send("R6 offset cost 1", 21, R, 1'b1);
    wr(3'd4, 32'h0680);       // adjust -4 tokens
    send("R6 negative adjust cost 100", 104, G, 1'b0);
    send("R7 cost clamps to 1/256", 4, R, 1'b1);
    wr(3'd4, 32'h0100);
    send("R11 cost write refills", 100, G, 1'b0);
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_bytes();
    t_sat_and_order();
    t_rdiv();
    t_yellow();
    t_pps();
    t_offset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule